// File: doc/BRIEF.md
# Prioritised Two-Level Interrupt Arbiter

This block sits beside an instruction pipeline and decides, once per completed instruction, whether execution must divert into an interrupt handler. It receives two active-low request pins, one for a fast interrupt and one for a normal interrupt. Both pins are asynchronous to the core clock and are resynchronised before use. It also holds the two disable bits that gate each request, and it reports which handler to enter.

At every instruction boundary the arbiter examines the synchronised requests against the current disable bits. The fast request wins when both are eligible. Entering the fast handler disables both requests. Entering the normal handler disables only the normal request. The arbiter also captures a link value: the handler returns by subtracting four from it, so it is the address of the next instruction plus four.

Software may rewrite the two disable bits, but only while the core runs in a privileged mode. A write attempted from user mode is dropped.

Top module: `intr_gate`

## Requirements
- R1: After reset both disable bits (`mask_f`, `mask_i`) read 1 and `exc_take` reads 0.
- R2: The request pins are active-low levels. A pin driven low just after clock edge e0 is first able to cause an entry on edge e3, which is two synchronizer flops plus the decision register.
- R3: An entry is decided only on an edge where `insn_done` is 1. While `insn_done` is 0, `exc_take` stays 0 whatever the requests do.
- R4: A fast request is ignored while `mask_f` is 1. A normal request is ignored while `mask_i` is 1. The decision on an edge uses the disable bits as they stood before that edge.
- R5: When both requests are eligible on the same boundary, the fast one is taken and `exc_kind` is 1.
- R6: Taking the fast request sets both `mask_f` and `mask_i` to 1.
- R7: Taking the normal request (`exc_kind` 0) sets `mask_i` to 1 and leaves `mask_f` unchanged.
- R8: When `mask_wr` is 1 and `priv_mode` is 1, `mask_f` and `mask_i` take `mask_wr_f` and `mask_wr_i` on the next edge. When `priv_mode` is 0, the write leaves both bits unchanged.
- R9: If a privileged write and an entry fall on the same edge, the written values are applied first, and the entry then forces its disable bits to 1.
- R10: `exc_take` is high for one cycle per entry. On that cycle `exc_link` equals `ret_addr` + 4, with `ret_addr` sampled on the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_req_n | input | 1 | Fast interrupt request pin, active low, asynchronous |
| norm_req_n | input | 1 | Normal interrupt request pin, active low, asynchronous |
| priv_mode | input | 1 | 1 when the core runs in a privileged mode |
| mask_wr | input | 1 | Request to rewrite the disable bits |
| mask_wr_f | input | 1 | New value for the fast disable bit |
| mask_wr_i | input | 1 | New value for the normal disable bit |
| insn_done | input | 1 | Instruction-boundary strobe |
| ret_addr | input | ADDR_W | Address of the next instruction to execute |
| exc_take | output | 1 | One-cycle entry pulse |
| exc_kind | output | 1 | Kind of entry: 0 normal, 1 fast |
| mask_f | output | 1 | Fast request disable bit |
| mask_i | output | 1 | Normal request disable bit |
| exc_link | output | ADDR_W | Saved link value for the handler |

## Verification
The bench builds the block with its defaults: a 32-bit address, two synchronizer stages and a link offset of four. Two stages make the three-edge request latency of R2 an exact, countable window. The 32-bit link width lets addresses near the top of the range wrap in the link adder during the random phase. A behavioural model keeps its own history of the pin values and its own disable bits, and it is compared against the outputs on every clock. Directed phases cover the following:
- the write gating by privilege,
- a held request waiting for a boundary,
- the priority between the two kinds,
- a privileged write and an entry falling on the same edge.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;

    typedef enum logic {
        KIND_NORMAL = 1'b0,
        KIND_FAST   = 1'b1
    } exc_kind_e;

    typedef struct packed {
        logic f;
        logic i;
    } mask_t;

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] req
);

    localparam int LAST = STAGES - 1;

    initial begin
        assert (STAGES >= 2) else $error("intr_sync needs at least two stages");
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], pin_n[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign req[g] = ~chain_q[LAST];
    end

endmodule

// File: rtl/intr_decide.sv
module intr_decide
    import intr_gate_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINK_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_req,
    input  logic              norm_req,
    input  logic              priv,
    input  logic              wr_en,
    input  mask_t             wr_mask,
    input  logic              insn_end,
    input  logic [ADDR_W-1:0] ret_pc,
    output logic              take,
    output exc_kind_e         kind,
    output mask_t             mask,
    output logic [ADDR_W-1:0] link
);

    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(LINK_OFF);

    typedef struct packed {
        logic              take;
        exc_kind_e         kind;
        mask_t             mask;
        logic [ADDR_W-1:0] link;
    } state_t;

    state_t cur_q, nxt_d;
    logic   fast_ok, norm_ok;

    always_comb begin
        nxt_d   = cur_q;
        nxt_d.take = 1'b0;
        fast_ok = fast_req && !cur_q.mask.f;
        norm_ok = norm_req && !cur_q.mask.i;
        if (wr_en && priv) begin
            nxt_d.mask = wr_mask;
        end
        if (insn_end && (fast_ok || norm_ok)) begin
            nxt_d.take   = 1'b1;
            nxt_d.kind   = fast_ok ? KIND_FAST : KIND_NORMAL;
            nxt_d.link   = ret_pc + OFF;
            nxt_d.mask.i = 1'b1;
            if (fast_ok) nxt_d.mask.f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.take <= 1'b0;
            cur_q.kind <= KIND_NORMAL;
            cur_q.mask <= '{f: 1'b1, i: 1'b1};
            cur_q.link <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign take = cur_q.take;
    assign kind = cur_q.kind;
    assign mask = cur_q.mask;
    assign link = cur_q.link;

    // R3: an entry only follows a boundary strobe
    assert_take_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.take |-> $past(insn_end));

    // R4: both disable bits set at a boundary means no entry
    assert_masked_no_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && cur_q.mask.f && cur_q.mask.i) |=> !cur_q.take);

    // R5: a normal entry never happens while a fast one was eligible
    assert_fast_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.take && cur_q.kind == KIND_NORMAL) |-> !($past(fast_req) && !$past(cur_q.mask.f)));

    // R6: fast entry leaves both requests disabled
    assert_fast_sets_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.take && cur_q.kind == KIND_FAST) |-> (cur_q.mask.f && cur_q.mask.i));

    // R7: normal entry keeps the fast disable bit as it was
    assert_norm_keeps_f_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.take && cur_q.kind == KIND_NORMAL && !$past(wr_en && priv))
        |-> (cur_q.mask.i && cur_q.mask.f == $past(cur_q.mask.f)));

    // R8: user-mode writes are dropped
    assert_user_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv) |=> (cur_q.take || $stable(cur_q.mask)));

    // R10: link captured from the return address on the deciding edge
    assert_link_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.take |-> cur_q.link == $past(ret_pc) + OFF);

endmodule

// File: rtl/intr_gate.sv
module intr_gate
    import intr_gate_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LINK_OFF    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_req_n,
    input  logic              norm_req_n,
    input  logic              priv_mode,
    input  logic              mask_wr,
    input  logic              mask_wr_f,
    input  logic              mask_wr_i,
    input  logic              insn_done,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic              exc_take,
    output logic              exc_kind,
    output logic              mask_f,
    output logic              mask_i,
    output logic [ADDR_W-1:0] exc_link
);

    localparam int N_REQ = 2;
    localparam int FAST_IDX = 1;
    localparam int NORM_IDX = 0;

    logic [N_REQ-1:0] req_sync;
    exc_kind_e        kind_w;
    mask_t            mask_w;
    mask_t            wr_mask_w;

    assign wr_mask_w = '{f: mask_wr_f, i: mask_wr_i};

    intr_sync #(
        .WIDTH (N_REQ),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_n({fast_req_n, norm_req_n}),
        .req  (req_sync)
    );

    intr_decide #(
        .ADDR_W  (ADDR_W),
        .LINK_OFF(LINK_OFF)
    ) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_req(req_sync[FAST_IDX]),
        .norm_req(req_sync[NORM_IDX]),
        .priv    (priv_mode),
        .wr_en   (mask_wr),
        .wr_mask (wr_mask_w),
        .insn_end(insn_done),
        .ret_pc  (ret_addr),
        .take    (exc_take),
        .kind    (kind_w),
        .mask    (mask_w),
        .link    (exc_link)
    );

    assign exc_kind = kind_w;
    assign mask_f   = mask_w.f;
    assign mask_i   = mask_w.i;

endmodule

// File: tb/intr_gate_test.sv
`timescale 1ns/1ps
module intr_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_req_n = 1'b1, norm_req_n = 1'b1;
    logic        priv_mode = 1'b0, mask_wr = 1'b0, mask_wr_f = 1'b0, mask_wr_i = 1'b0;
    logic        insn_done = 1'b0;
    logic [31:0] ret_addr = '0;
    logic        exc_take, exc_kind, mask_f, mask_i;
    logic [31:0] exc_link;

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    intr_gate uut (
        .clk(clk), .rst_n(rst_n), .fast_req_n(fast_req_n), .norm_req_n(norm_req_n),
        .priv_mode(priv_mode), .mask_wr(mask_wr), .mask_wr_f(mask_wr_f), .mask_wr_i(mask_wr_i),
        .insn_done(insn_done), .ret_addr(ret_addr), .exc_take(exc_take), .exc_kind(exc_kind),
        .mask_f(mask_f), .mask_i(mask_i), .exc_link(exc_link)
    );

    // Reference model: pin history queues and plain mask bits
    logic fhist[$];
    logic ihist[$];
    logic m_take, m_kind, m_f, m_i;
    logic [31:0] m_link;

    always @(posedge clk) begin
        if (!rst_n) begin
            fhist = '{1'b1, 1'b1};
            ihist = '{1'b1, 1'b1};
            m_take <= 1'b0; m_kind <= 1'b0; m_f <= 1'b1; m_i <= 1'b1; m_link <= '0;
        end else begin
            bit fs, is, fo, io, nf, ni;
            fs = !fhist[0];
            is = !ihist[0];
            void'(fhist.pop_front()); fhist.push_back(fast_req_n);
            void'(ihist.pop_front()); ihist.push_back(norm_req_n);
            fo = fs && !m_f;
            io = is && !m_i;
            nf = m_f; ni = m_i;
            if (mask_wr && priv_mode) begin nf = mask_wr_f; ni = mask_wr_i; end
            m_take <= 1'b0;
            if (insn_done && (fo || io)) begin
                m_take <= 1'b1;
                m_kind <= fo;
                m_link <= ret_addr + 32'd4;
                ni = 1'b1;
                if (fo) nf = 1'b1;
            end
            m_f <= nf; m_i <= ni;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk({phase, " model take"}, exc_take, m_take);
            chk({phase, " model mask_f"}, mask_f, m_f);
            chk({phase, " model mask_i"}, mask_i, m_i);
            if (m_take) begin
                chk({phase, " model kind"}, exc_kind, m_kind);
                chk({phase, " model link"}, exc_link, m_link);
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pwrite(input logic f, input logic i, input logic p);
        priv_mode = p; mask_wr = 1'b1; mask_wr_f = f; mask_wr_i = i;
        step();
        mask_wr = 1'b0; priv_mode = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ret_addr = 32'h100;
        step(3);
        rst_n = 1'b1;
        step();
        phase = "R1";
        chk("R1 reset mask_f", mask_f, 1);
        chk("R1 reset mask_i", mask_i, 1);
        chk("R1 reset take", exc_take, 0);

        phase = "R8";
        pwrite(1'b0, 1'b0, 1'b0);
        chk("R8 user write mask_f", mask_f, 1);
        chk("R8 user write mask_i", mask_i, 1);
        pwrite(1'b0, 1'b0, 1'b1);
        chk("R8 priv write mask_f", mask_f, 0);
        chk("R8 priv write mask_i", mask_i, 0);

        phase = "R3";
        insn_done = 1'b0; norm_req_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R3 no boundary no take", exc_take, 0);
        end
        insn_done = 1'b1;
        step();
        phase = "R7";
        chk("R3 take at boundary", exc_take, 1);
        chk("R7 kind normal", exc_kind, 0);
        chk("R7 mask_i set", mask_i, 1);
        chk("R7 mask_f kept", mask_f, 0);
        chk("R10 link value", exc_link, 32'h104);
        step();
        chk("R10 single pulse", exc_take, 0);
        norm_req_n = 1'b1;

        phase = "R2";
        ret_addr = 32'h2000;
        step(3);
        pwrite(1'b0, 1'b0, 1'b1);
        fast_req_n = 1'b0;
        step();
        chk("R2 edge1 no take", exc_take, 0);
        step();
        chk("R2 edge2 no take", exc_take, 0);
        step();
        chk("R2 edge3 take", exc_take, 1);
        chk("R2 kind fast", exc_kind, 1);
        chk("R6 mask_f set", mask_f, 1);
        chk("R6 mask_i set", mask_i, 1);
        chk("R10 link fast", exc_link, 32'h2004);

        phase = "R4";
        norm_req_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R4 both masked no take", exc_take, 0);
        end
        pwrite(1'b1, 1'b0, 1'b1);
        chk("R4 old masks used on write edge", exc_take, 0);
        step();
        chk("R4 normal taken with F set", exc_take, 1);
        chk("R4 kind normal", exc_kind, 0);

        phase = "R5";
        pwrite(1'b0, 1'b0, 1'b1);
        chk("R5 old masks on write edge", exc_take, 0);
        step();
        chk("R5 take both pending", exc_take, 1);
        chk("R5 fast wins", exc_kind, 1);

        phase = "R9";
        insn_done = 1'b0; fast_req_n = 1'b1;
        step(3);
        pwrite(1'b0, 1'b0, 1'b1);
        insn_done = 1'b1; mask_wr = 1'b1; mask_wr_f = 1'b1; mask_wr_i = 1'b0;
        step();
        mask_wr = 1'b0;
        chk("R9 take with write", exc_take, 1);
        chk("R9 kind normal", exc_kind, 0);
        chk("R9 written F", mask_f, 1);
        chk("R9 entry forces I", mask_i, 1);
        norm_req_n = 1'b1;

        phase = "random R4 R5 R8 R10";
        for (int k = 0; k < 400; k++) begin
            fast_req_n = ($urandom_range(0, 3) != 0);
            norm_req_n = ($urandom_range(0, 2) != 0);
            priv_mode  = $urandom_range(0, 1);
            mask_wr    = ($urandom_range(0, 3) == 0);
            mask_wr_f  = ($urandom_range(0, 2) == 0);
            mask_wr_i  = ($urandom_range(0, 2) == 0);
            insn_done  = $urandom_range(0, 1);
            ret_addr   = (k % 50 == 0) ? 32'hFFFF_FFFE : $urandom;
            step();
        end
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule